// File: doc/BRIEF.md
# Clock-Synchronous Serial Port

This block moves short words between a parallel register port and a pair of serial data lines, timed by a serial clock. Software writes a control byte to set the frame length (any value from 2 to 8 bits), which bit goes out first, whether the outgoing line is driven, whether incoming bits are kept, and whether the port makes the serial clock itself or follows one supplied from outside. Writing the data register starts a transfer. One interrupt pulse marks the end of the transfer.

As clock master, the port toggles its serial clock output once for each strobe on a tick enable that comes from a divider or timer elsewhere on the chip. As slave, it passes the external serial clock through a synchronizer and acts on the edges it sees. In both cases outgoing bits change on a falling clock edge and incoming bits are sampled on a rising edge. Received words are right-aligned, and the bits above the frame read as zero.

Top module: `sync_serial_port`

## Requirements
- R1: After reset the status register (address 2, bit 0 = busy) and `irq` are 0, `sdo` and `sclk_o` are 1, and the control (address 0) and receive (address 1) registers read 0.
- R2: Control bits [2:0] hold the frame length minus one. Codes 1 to 7 give frames of 2 to 8 bits, and code 0 gives 2 bits. Each transfer moves exactly that many bits.
- R3: Control bit 3 selects the order. When it is 1, data bit 0 goes first. When it is 0, bit length-1 goes first. Reception assembles the word in the same order.
- R4: In master mode (control bit 6 = 1), `sclk_o` is high while idle and gives exactly one low pulse per bit. `sdo` changes only together with a falling edge of `sclk_o`.
- R5: After a transfer with reception enabled, the receive register holds the received frame right-aligned, with every bit above the frame at zero.
- R6: With control bit 4 (transmit enable) at 0, `sdo` stays 1. With control bit 5 (receive enable) at 0, the receive register keeps its previous value through the transfer.
- R7: `irq` is a single-cycle pulse, raised in the cycle in which busy falls, once per transfer, after the last bit has been sampled.
- R8: While busy is 1, writes to the control and data registers are ignored and do not start or alter a transfer.
- R9: In slave mode (control bit 6 = 0), `sclk_oe` is 0 and `sclk_o` stays 1. `sclk_i` is synchronized, and its falling and rising edges shift data out and in.
- R10: While no transfer is in progress, `tick` strobes and `sclk_i` edges have no effect: `sclk_o` stays high and the receive register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Bit-rate enable, one half serial period per strobe in master mode |
| addr | input | 2 | Register address: 0 control, 1 data, 2 status |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data for `addr` |
| sclk_i | input | 1 | External serial clock (slave mode) |
| sclk_o | output | 1 | Generated serial clock (master mode) |
| sclk_oe | output | 1 | High when the port drives the serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| irq | output | 1 | Transfer-complete pulse |

## Verification
The bench builds the block with its defaults: an 8-bit maximum frame and a two-stage synchronizer. With these values it can reach every length code, both bit orders and all four transmit/receive enable combinations, using a small number of cycles per frame. In master mode it sweeps every frame length with both orders against two data patterns, acting as the remote device on the wires, and in slave mode it drives a slow external clock through every length and order. Expected serial words and received values are found by masking the pattern to the frame length.

// File: rtl/ssp_pkg.sv
`timescale 1ns/1ps
package ssp_pkg;
   localparam int REG_W   = 8;
   localparam int ADDR_W  = 2;
   localparam int LEN_W   = 3;
   localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
   localparam logic [ADDR_W-1:0] A_DATA = 2'd1;
   localparam logic [ADDR_W-1:0] A_STAT = 2'd2;
   localparam int B_LSB    = 3;
   localparam int B_TXEN   = 4;
   localparam int B_RXEN   = 5;
   localparam int B_MASTER = 6;
   localparam int CTRL_W   = 7;

   typedef struct packed {
      logic             master;
      logic             rx_en;
      logic             tx_en;
      logic             lsb_first;
      logic [LEN_W-1:0] len_code;
   } ctrl_t;
endpackage

// File: rtl/ssp_regs.sv
`timescale 1ns/1ps
module ssp_regs
   import ssp_pkg::*;
#(
   parameter int MAX_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 wr_en,
   input  logic [REG_W-1:0]     wr_data,
   input  logic                 busy,
   input  logic [MAX_BITS-1:0]  rx_word,
   output ctrl_t                ctrl,
   output logic                 start,
   output logic [MAX_BITS-1:0]  tx_word,
   output logic [REG_W-1:0]     rd_data
);
   logic wr_ctrl;

   assign wr_ctrl = wr_en && (addr == A_CTRL) && !busy;
   assign start   = wr_en && (addr == A_DATA) && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl    <= '0;
         tx_word <= '0;
      end else begin
         if (wr_ctrl) ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
         if (start)   tx_word <= wr_data[MAX_BITS-1:0];
      end
   end

   always_comb begin
      unique case (addr)
         A_CTRL:  rd_data = REG_W'(ctrl);
         A_DATA:  rd_data = REG_W'(rx_word);
         A_STAT:  rd_data = REG_W'(busy);
         default: rd_data = '0;
      endcase
   end
endmodule

// File: rtl/ssp_clkgen.sv
`timescale 1ns/1ps
module ssp_clkgen #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic master,
   input  logic busy,
   input  logic tick,
   input  logic sclk_i,
   output logic sclk_o,
   output logic fall_stb,
   output logic rise_stb
);
   logic sclk_q;
   logic ext_now;
   logic ext_prev;
   logic m_fall, m_rise, s_fall, s_rise;

   // master: one toggle per tick during a transfer, idle high
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                sclk_q <= 1'b1;
      else if (!master)          sclk_q <= 1'b1;
      else if (busy && tick)     sclk_q <= ~sclk_q;
   end

   assign m_fall = master && busy && tick && sclk_q;
   assign m_rise = master && busy && tick && !sclk_q;

   // slave: synchronizer chain, depth chosen by parameter
   logic [SYNC_STAGES-1:0] sync_q;
   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[0] <= 1'b1;
               else        sync_q[0] <= sclk_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[s] <= 1'b1;
               else        sync_q[s] <= sync_q[s-1];
            end
         end
      end
   endgenerate

   assign ext_now = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ext_prev <= 1'b1;
      else        ext_prev <= ext_now;
   end

   assign s_fall = !master && ext_prev && !ext_now;
   assign s_rise = !master && !ext_prev && ext_now;

   assign sclk_o   = sclk_q;
   assign fall_stb = m_fall || s_fall;
   assign rise_stb = m_rise || s_rise;
endmodule

// File: rtl/ssp_shifter.sv
`timescale 1ns/1ps
module ssp_shifter
   import ssp_pkg::*;
#(
   parameter int MAX_BITS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                fall_stb,
   input  logic                rise_stb,
   input  logic [LEN_W-1:0]    len_code,
   input  logic                lsb_first,
   input  logic                tx_en,
   input  logic                rx_en,
   input  logic                sdi,
   input  logic [MAX_BITS-1:0] tx_word,
   output logic                busy,
   output logic                done,
   output logic                sdo,
   output logic [MAX_BITS-1:0] rx_word
);
   localparam logic [LEN_W-1:0] TOP_IDX = LEN_W'(MAX_BITS - 1);

   logic [LEN_W-1:0]    idx;
   logic [LEN_W-1:0]    last_idx;
   logic [LEN_W-1:0]    rev_idx;
   logic [MAX_BITS-1:0] acc;
   logic [MAX_BITS-1:0] acc_next;
   logic                tx_bit;
   logic                sdo_q;

   // length code 0 means two bits; codes past the maximum are clamped
   always_comb begin
      if (len_code == '0)          last_idx = LEN_W'(1);
      else if (len_code > TOP_IDX) last_idx = TOP_IDX;
      else                         last_idx = len_code;
   end

   assign rev_idx = last_idx - idx;
   assign tx_bit  = lsb_first ? tx_word[idx] : tx_word[rev_idx];

   always_comb begin
      if (lsb_first) acc_next = acc | (MAX_BITS'(sdi) << idx);
      else           acc_next = {acc[MAX_BITS-2:0], sdi};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         done    <= 1'b0;
         idx     <= '0;
         acc     <= '0;
         sdo_q   <= 1'b1;
         rx_word <= '0;
      end else begin
         done <= 1'b0;
         if (start) begin
            busy <= 1'b1;
            idx  <= '0;
            acc  <= '0;
         end else if (busy) begin
            if (fall_stb && tx_en) sdo_q <= tx_bit;
            if (rise_stb) begin
               acc <= acc_next;
               if (idx == last_idx) begin
                  busy <= 1'b0;
                  done <= 1'b1;
                  if (rx_en) rx_word <= acc_next;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
         end
      end
   end

   assign sdo = tx_en ? sdo_q : 1'b1;
endmodule

// File: rtl/sync_serial_port.sv
`timescale 1ns/1ps
module sync_serial_port
   import ssp_pkg::*;
#(
   parameter int MAX_BITS    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [1:0]        addr,
   input  logic              wr_en,
   input  logic [7:0]        wr_data,
   output logic [7:0]        rd_data,
   input  logic              sclk_i,
   output logic              sclk_o,
   output logic              sclk_oe,
   input  logic              sdi,
   output logic              sdo,
   output logic              irq
);
   if (MAX_BITS < 2 || MAX_BITS > REG_W) begin : g_bad_bits
      $error("MAX_BITS must lie in 2..8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   ctrl_t               ctrl;
   logic [CTRL_W-1:0]   ctrl_byte;
   logic                start, busy, fall_stb, rise_stb;
   logic [MAX_BITS-1:0] tx_word, rx_word;

   assign ctrl_byte = ctrl;
   assign sclk_oe   = ctrl.master;

   ssp_regs #(.MAX_BITS(MAX_BITS)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
      .wr_data(wr_data), .busy(busy), .rx_word(rx_word),
      .ctrl(ctrl), .start(start), .tx_word(tx_word), .rd_data(rd_data)
   );

   ssp_clkgen #(.SYNC_STAGES(SYNC_STAGES)) u_clk (
      .clk(clk), .rst_n(rst_n), .master(ctrl.master), .busy(busy),
      .tick(tick), .sclk_i(sclk_i), .sclk_o(sclk_o),
      .fall_stb(fall_stb), .rise_stb(rise_stb)
   );

   ssp_shifter #(.MAX_BITS(MAX_BITS)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(start), .fall_stb(fall_stb),
      .rise_stb(rise_stb), .len_code(ctrl.len_code),
      .lsb_first(ctrl.lsb_first), .tx_en(ctrl.tx_en), .rx_en(ctrl.rx_en),
      .sdi(sdi), .tx_word(tx_word), .busy(busy), .done(irq),
      .sdo(sdo), .rx_word(rx_word)
   );
endmodule

// File: rtl/sync_serial_port_chk.sv
`timescale 1ns/1ps
module sync_serial_port_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       busy,
   input logic       irq,
   input logic       sclk_o,
   input logic       sclk_oe,
   input logic       sdo,
   input logic [6:0] ctrl_byte
);
   // R7: completion pulse lasts one cycle
   p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   // R7: pulse coincides with the end of busy
   p_irq_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (!busy && $past(busy)));
   // R4: master clock idles high
   p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_byte[6] && !busy) |-> sclk_o);
   // R4: data out moves only with a falling serial clock
   p_sdo_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_byte[6] && $past(busy) && !$stable(sdo)) |-> $fell(sclk_o));
   // R8: configuration frozen during a transfer
   p_ctrl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(ctrl_byte));
   // R9: slave mode leaves the clock line undriven and high
   p_slave_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_byte[6] |-> (sclk_o && !sclk_oe));
endmodule

bind sync_serial_port sync_serial_port_chk u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .irq(irq), .sclk_o(sclk_o),
   .sclk_oe(sclk_oe), .sdo(sdo), .ctrl_byte(ctrl_byte)
);

// File: tb/sync_serial_port_tb.sv
`timescale 1ns/1ps
module sync_serial_port_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [1:0] addr = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       sclk_i = 1'b1;
   logic       sclk_o, sclk_oe;
   logic       sdi = 1'b0;
   logic       sdo, irq;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   sync_serial_port u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .sclk_i(sclk_i),
      .sclk_o(sclk_o), .sclk_oe(sclk_oe), .sdi(sdi), .sdo(sdo), .irq(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      addr = a;
      #0.1;
      d = rd_data;
   endtask

   function automatic logic [7:0] ctl(input int n, input bit lsb, input bit tx,
                                      input bit rx, input bit mst);
      return {1'b0, mst, rx, tx, lsb, 3'(n - 1)};
   endfunction

   function automatic int bpos(input int n, input bit lsb, input int k);
      return lsb ? k : n - 1 - k;
   endfunction

   // master transfer; bench acts as the remote device
   task automatic master_xfer(input int n, input bit lsb, input bit tx, input bit rx,
                              input logic [7:0] tdat, input logic [7:0] pat,
                              input logic [7:0] rx_before);
      logic [7:0] got, r, mask;
      int rises, falls, irqs, kf, kr;
      logic prev;
      mask = 8'((1 << n) - 1);
      wr(2'd0, ctl(n, lsb, tx, rx, 1'b1));
      wr(2'd1, tdat);
      got = '0; rises = 0; falls = 0; irqs = 0; kf = 0; kr = 0;
      prev = 1'b1;
      for (int c = 0; c < 200; c++) begin
         @(negedge clk);
         if (prev && !sclk_o) begin
            falls++;
            sdi = pat[bpos(n, lsb, kf)];
            kf++;
         end
         if (!prev && sclk_o) begin
            rises++;
            if (kr < n) got[bpos(n, lsb, kr)] = sdo;
            kr++;
         end
         prev = sclk_o;
         if (irq) begin irqs++; break; end
      end
      chk("R2 bit count", rises, n);
      chk("R4 low pulses", falls, n);
      chk("R7 one irq", irqs, 1);
      if (tx) chk("R3 serial out order", int'(got), int'(tdat & mask));
      else    chk("R6 tx off sdo high", int'(got), int'(mask));
      rd(2'd2, r);
      chk("R7 busy cleared", int'(r), 0);
      @(negedge clk);
      chk("R7 irq single", int'(irq), 0);
      chk("R4 idle high", int'(sclk_o), 1);
      rd(2'd1, r);
      if (rx) chk("R5 rx aligned", int'(r), int'(pat & mask));
      else    chk("R6 rx kept", int'(r), int'(rx_before));
   endtask

   task automatic wait_cnt(input int cyc, inout int irqs);
      for (int c = 0; c < cyc; c++) begin
         @(negedge clk);
         if (irq) irqs++;
      end
   endtask

   task automatic slave_xfer(input int n, input bit lsb, input logic [7:0] tdat,
                             input logic [7:0] pat);
      logic [7:0] got, r, mask;
      int irqs;
      mask = 8'((1 << n) - 1);
      wr(2'd0, ctl(n, lsb, 1'b1, 1'b1, 1'b0));
      chk("R9 sclk_oe low", int'(sclk_oe), 0);
      wr(2'd1, tdat);
      got = '0; irqs = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         sclk_i = 1'b0;
         sdi = pat[bpos(n, lsb, k)];
         wait_cnt(6, irqs);
         got[bpos(n, lsb, k)] = sdo;
         sclk_i = 1'b1;
         wait_cnt(6, irqs);
      end
      chk("R9 slave serial out", int'(got), int'(tdat & mask));
      chk("R9 slave irq", irqs, 1);
      chk("R9 sclk_o high", int'(sclk_o), 1);
      rd(2'd1, r);
      chk("R9 slave rx", int'(r), int'(pat & mask));
   endtask

   initial begin
      forever begin
         @(negedge clk);
         tick = ~tick;
      end
   end

   initial begin
      #750000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] r, last_rx;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(2'd2, r); chk("R1 busy", int'(r), 0);
      rd(2'd0, r); chk("R1 ctrl", int'(r), 0);
      rd(2'd1, r); chk("R1 rx", int'(r), 0);
      chk("R1 irq", int'(irq), 0);
      chk("R1 sdo", int'(sdo), 1);
      chk("R1 sclk_o", int'(sclk_o), 1);

      // R2 R3 R5 sweep: all lengths, both orders, full duplex
      for (int n = 2; n <= 8; n++)
         for (int o = 0; o < 2; o++) begin
            master_xfer(n, o[0], 1'b1, 1'b1, 8'hA5, 8'h3C, 8'h00);
            master_xfer(n, o[0], 1'b1, 1'b1, 8'h5B, 8'hE6, 8'h00);
         end

      // R6 transmit only keeps rx, receive only keeps sdo high
      rd(2'd1, last_rx);
      master_xfer(5, 1'b0, 1'b1, 1'b0, 8'h13, 8'h0F, last_rx);
      master_xfer(6, 1'b1, 1'b0, 1'b1, 8'hFF, 8'h2A, 8'h00);

      // R2 length code 0 means two bits
      wr(2'd0, 8'b0111_0000);
      wr(2'd1, 8'h02);
      begin
         int rises;
         logic prev;
         rises = 0; prev = 1'b1;
         for (int c = 0; c < 100; c++) begin
            @(negedge clk);
            if (!prev && sclk_o) rises++;
            prev = sclk_o;
            if (irq) break;
         end
         chk("R2 code0 two bits", rises, 2);
      end

      // R10 ticks while idle leave the clock high
      repeat (10) @(negedge clk);
      chk("R10 idle tick", int'(sclk_o), 1);

      // R8 writes during a transfer are ignored
      sdi = 1'b1;
      wr(2'd0, ctl(8, 1'b0, 1'b1, 1'b1, 1'b1));
      wr(2'd1, 8'h81);
      rd(2'd2, r); chk("R8 busy set", int'(r), 1);
      wr(2'd0, 8'h00);
      wr(2'd1, 8'h00);
      for (int c = 0; c < 200; c++) begin
         @(negedge clk);
         if (irq) break;
      end
      rd(2'd0, r); chk("R8 ctrl kept", int'(r), int'(ctl(8, 1'b0, 1'b1, 1'b1, 1'b1)));
      rd(2'd1, r); chk("R8 rx full", int'(r), 8'hFF);
      repeat (4) @(negedge clk);
      rd(2'd2, r); chk("R8 no restart", int'(r), 0);

      // R9 slave sweep
      for (int n = 2; n <= 8; n++)
         for (int o = 0; o < 2; o++)
            slave_xfer(n, o[0], 8'h69, 8'hB4);

      // R10 external clock edges while idle are ignored
      rd(2'd1, last_rx);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk); sclk_i = 1'b0; sdi = ~sdi;
         repeat (5) @(negedge clk);
         sclk_i = 1'b1;
         repeat (5) @(negedge clk);
      end
      rd(2'd1, r); chk("R10 slave idle rx", int'(r), int'(last_rx));
      rd(2'd2, r); chk("R10 slave idle busy", int'(r), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule